// File: doc/BRIEF.md
# Serial Flash Programming Slave

This block is the target side of a four-wire serial port that loads and inspects an on-chip program flash while the chip's programming input is held high. The external programmer drives SCK and MOSI and samples MISO. The block brings both inputs into the system clock domain, samples MOSI on each detected SCK rise, and updates MISO after each detected SCK fall. Each instruction is four bytes long, except the two page commands. After their two header bytes, those commands stream 256 data bytes.

The block turns instructions into single-cycle strobes on a synchronous memory port. The attached flash array returns read data one clock after a read strobe. The block also holds the lock level, which is raised one step at a time and cleared only by a chip erase. Nothing is accepted until the enable handshake has been seen. Dropping the programming input discards the enabled state and any partial instruction.

Top module: `isp_slave`

## Requirements
- R1: While prog_en_i is low, the block is idle. It makes no memory access, drives MISO low, discards any partial instruction and clears the enabled state. Lock level and memory contents are kept. After prog_en_i rises again, commands are ignored until the enable handshake is repeated.
- R2: After prog_en_i rises, SCK edges are discarded until SCK has been low for 64 consecutive system clocks. If SCK goes high earlier, the count restarts. Every SCK half period must last at least 8 system clocks.
- R3: The bytes 0xAC, 0x53, any, any form the enable handshake. During the fourth byte the block returns 0x69 on MISO, whether or not it is already enabled. From the end of that byte the block is enabled.
- R4: Before the block is enabled, every instruction other than the enable handshake is decoded but has no effect. It causes no memory access and no lock change, and MISO stays 0x00 during its fourth byte.
- R5: Byte write is 0x40, hi, lo, data. Byte read is 0x20, hi, lo, any. The address is {hi[4:0], lo} (13 bits), so the upper three bits of hi are ignored. Read data is shifted out MSB first during the fourth byte, and a location never written reads 0xFF.
- R6: The bytes 0xAC, 100x_xxxx, any, any perform a chip erase. Every location then reads 0xFF and the lock level returns to mode 1.
- R7: The bytes 0xAC, 1110_00ab, any, any request lock mode {a,b}+1. The request is accepted only when {a,b} is exactly one more than the current level, so modes 2, 3 and 4 must be set in that order. Any other request changes nothing.
- R8: Lock read is 0x24, any, any, any. During the fourth byte, bits 2, 3 and 4 carry lock bits 1, 2 and 3, with 1 meaning programmed, and all other bits are 0. Mode 1 reads 0x00, mode 2 reads 0x04, mode 3 reads 0x0C and mode 4 reads 0x1C.
- R9: Signature read is 0x28, any, idx, any. During the fourth byte it returns 0xA5, 0x3C or 0x0F for idx[1:0] = 0, 1 or 2, and 0xFF for 3.
- R10: Page write is 0x50 followed by hi and exactly 256 data bytes, which are written to {hi[4:0], 0..255} in order. The next byte after them is decoded as a new instruction.
- R11: Page read is 0x30 followed by hi, and then 256 byte slots. Slot n returns the content of {hi[4:0], n}, MSB first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low system reset |
| prog_en_i | input | 1 | Programming mode request, active high, asynchronous |
| sck_i | input | 1 | Serial clock from the programmer, asynchronous |
| mosi_i | input | 1 | Serial data from the programmer, asynchronous |
| miso_o | output | 1 | Serial data to the programmer |
| mem_addr_o | output | 13 | Flash byte address |
| mem_re_o | output | 1 | Read strobe; data is expected on mem_rdata_i one clock later |
| mem_we_o | output | 1 | Single-cycle byte write strobe |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data from the flash array |
| mem_erase_o | output | 1 | Single-cycle strobe that sets the whole array to 0xFF |

## Verification
The assertions assume that the programmer keeps the SCK half periods at least 8 system clocks long. They also assume that MOSI changes only while SCK is low, far enough from the rising edge that both synchronised inputs agree when the edge is detected. They further assume that the flash model answers exactly one clock after each read strobe. The stimulus keeps within these limits: it uses a 10-clock half period, changes MOSI mid-way through the low phase, and samples MISO just before each rise. The memory model registers its read data in a single stage.

// File: rtl/isp_pkg.sv
package isp_pkg;
  localparam int DATA_W = 8;

  localparam logic [7:0] OP_MULTI   = 8'hAC;
  localparam logic [7:0] OP_EN_KEY  = 8'h53;
  localparam logic [7:0] OP_BYTE_RD = 8'h20;
  localparam logic [7:0] OP_BYTE_WR = 8'h40;
  localparam logic [7:0] OP_LOCK_RD = 8'h24;
  localparam logic [7:0] OP_SIG_RD  = 8'h28;
  localparam logic [7:0] OP_PAGE_RD = 8'h30;
  localparam logic [7:0] OP_PAGE_WR = 8'h50;
  localparam logic [7:0] EN_ECHO    = 8'h69;

  typedef enum logic {ST_CMD, ST_PAGE} isp_state_e;
endpackage

// File: rtl/isp_sync.sv
module isp_sync #(
  parameter int STAGES  = 2,
  parameter int MIN_GAP = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic mosi_i,
  input  logic prog_i,
  output logic sck_o,
  output logic mosi_o,
  output logic prog_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int GW = $clog2(MIN_GAP + 1);

  logic [2:0] stg_q [STAGES];
  logic       sck_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
      sck_d_q <= 1'b0;
    end else begin
      stg_q[0] <= {prog_i, mosi_i, sck_i};
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
      sck_d_q <= stg_q[STAGES-1][0];
    end
  end

  assign sck_o  = stg_q[STAGES-1][0];
  assign mosi_o = stg_q[STAGES-1][1];
  assign prog_o = stg_q[STAGES-1][2];
  assign rise_o = sck_o & ~sck_d_q;
  assign fall_o = ~sck_o & sck_d_q;

  // spacing monitor for the input rate rule
  logic [GW-1:0] gap_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                gap_q <= GW'(MIN_GAP);
    else if (rise_o || fall_o)  gap_q <= '0;
    else if (gap_q != GW'(MIN_GAP)) gap_q <= gap_q + 1'b1;
  end

  AST_SCK_RATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_o && (rise_o || fall_o)) |-> (gap_q >= GW'(MIN_GAP - 1))); // R2
endmodule

// File: rtl/isp_guard.sv
module isp_guard #(
  parameter int GUARD_CYC = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic sck_i,
  input  logic rise_i,
  input  logic fall_i,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = $clog2(GUARD_CYC);

  logic [CW-1:0] cnt_q;
  logic          armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (!active_i) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (!armed_q) begin
      if (sck_i)                          cnt_q   <= '0;
      else if (cnt_q == CW'(GUARD_CYC-1)) armed_q <= 1'b1;
      else                                cnt_q   <= cnt_q + 1'b1;
    end
  end

  assign rise_o = rise_i & armed_q;
  assign fall_o = fall_i & armed_q;

  AST_ARM_AFTER_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(armed_q) |-> $past(!sck_i)); // R2
endmodule

// File: rtl/isp_shift.sv
module isp_shift #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         rise_i,
  input  logic         fall_i,
  input  logic         mosi_i,
  input  logic         load_i,
  input  logic [W-1:0] load_data_i,
  output logic         byte_done_o,
  output logic [W-1:0] rx_byte_o,
  output logic         miso_o
);
  localparam int BW = $clog2(W);

  logic [BW-1:0] bit_cnt_q;
  logic [W-1:0]  rx_q, tx_q;
  logic          done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt_q <= '0;
      rx_q      <= '0;
      tx_q      <= '0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (clr_i) begin
        bit_cnt_q <= '0;
        rx_q      <= '0;
        tx_q      <= '0;
      end else begin
        if (rise_i) begin
          rx_q <= {rx_q[W-2:0], mosi_i};
          if (bit_cnt_q == BW'(W-1)) begin
            bit_cnt_q <= '0;
            done_q    <= 1'b1;
          end else begin
            bit_cnt_q <= bit_cnt_q + 1'b1;
          end
        end
        // no shift on the fall that closes a byte: next MSB waits there
        if (load_i)                         tx_q <= load_data_i;
        else if (fall_i && bit_cnt_q != '0) tx_q <= {tx_q[W-2:0], 1'b0};
      end
    end
  end

  assign byte_done_o = done_q;
  assign rx_byte_o   = rx_q;
  assign miso_o      = tx_q[W-1];

  AST_IDLE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (bit_cnt_q == '0 && !miso_o)); // R1
endmodule

// File: rtl/isp_slave.sv
module isp_slave
  import isp_pkg::*;
#(
  parameter int          ADDR_W    = 13,
  parameter int          GUARD_CYC = 64,
  parameter int          MIN_GAP   = 8,
  parameter int          SYNC_STG  = 2,
  parameter int          SIG_N     = 3,
  parameter logic [23:0] SIG_IDS   = 24'h0F3CA5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prog_en_i,
  input  logic              sck_i,
  input  logic              mosi_i,
  output logic              miso_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_re_o,
  output logic              mem_we_o,
  output logic [7:0]        mem_wdata_o,
  input  logic [7:0]        mem_rdata_i,
  output logic              mem_erase_o
);
  localparam int AHI = ADDR_W - DATA_W;

  logic sck_s, mosi_s, active, rise_raw, fall_raw, rise, fall;
  logic byte_done, load;
  logic [7:0] rx_byte, load_data, imm_data;

  isp_sync #(.STAGES(SYNC_STG), .MIN_GAP(MIN_GAP)) u_sync (
    .clk_i, .rst_ni, .sck_i, .mosi_i, .prog_i(prog_en_i),
    .sck_o(sck_s), .mosi_o(mosi_s), .prog_o(active),
    .rise_o(rise_raw), .fall_o(fall_raw));

  isp_guard #(.GUARD_CYC(GUARD_CYC)) u_guard (
    .clk_i, .rst_ni, .active_i(active), .sck_i(sck_s),
    .rise_i(rise_raw), .fall_i(fall_raw), .rise_o(rise), .fall_o(fall));

  isp_shift #(.W(DATA_W)) u_shift (
    .clk_i, .rst_ni, .clr_i(!active), .rise_i(rise), .fall_i(fall),
    .mosi_i(mosi_s), .load_i(load), .load_data_i(load_data),
    .byte_done_o(byte_done), .rx_byte_o(rx_byte), .miso_o);

  isp_state_e        state_q;
  logic [1:0]        byte_idx_q, lock_q;
  logic [7:0]        op_q, hi_q, lo_q, page_cnt_q;
  logic              enabled_q, rd_wait_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        wdata_q;
  logic              we_q, re_q, erase_q;

  wire is_enable = (op_q == OP_MULTI) && (hi_q == OP_EN_KEY);
  wire [7:0] lock_byte = {3'b000, lock_q == 2'd3, lock_q >= 2'd2, lock_q >= 2'd1, 2'b00};

  always_comb begin
    imm_data = 8'h00;
    if (state_q == ST_CMD && byte_idx_q == 2'd2) begin
      if (is_enable) imm_data = EN_ECHO;
      else if (enabled_q && op_q == OP_LOCK_RD) imm_data = lock_byte;
      else if (enabled_q && op_q == OP_SIG_RD)
        imm_data = (int'(rx_byte[1:0]) < SIG_N) ? SIG_IDS[rx_byte[1:0]*8 +: 8] : 8'hFF;
    end
  end

  assign load      = byte_done | rd_wait_q;
  assign load_data = rd_wait_q ? mem_rdata_i : imm_data;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_CMD;
      byte_idx_q <= '0;
      lock_q     <= '0;
      op_q       <= '0;
      hi_q       <= '0;
      lo_q       <= '0;
      page_cnt_q <= '0;
      enabled_q  <= 1'b0;
      rd_wait_q  <= 1'b0;
      addr_q     <= '0;
      wdata_q    <= '0;
      we_q       <= 1'b0;
      re_q       <= 1'b0;
      erase_q    <= 1'b0;
    end else begin
      we_q      <= 1'b0;
      re_q      <= 1'b0;
      erase_q   <= 1'b0;
      rd_wait_q <= re_q;
      if (!active) begin
        state_q    <= ST_CMD;
        byte_idx_q <= '0;
        enabled_q  <= 1'b0;
      end else if (byte_done) begin
        if (state_q == ST_CMD) begin
          case (byte_idx_q)
            2'd0: begin
              op_q       <= rx_byte;
              byte_idx_q <= 2'd1;
            end
            2'd1: begin
              hi_q <= rx_byte;
              if (enabled_q && (op_q == OP_PAGE_RD || op_q == OP_PAGE_WR)) begin
                state_q    <= ST_PAGE;
                byte_idx_q <= '0;
                page_cnt_q <= '0;
                if (op_q == OP_PAGE_RD) begin
                  re_q   <= 1'b1;
                  addr_q <= {rx_byte[AHI-1:0], 8'h00};
                end
              end else begin
                byte_idx_q <= 2'd2;
              end
            end
            2'd2: begin
              lo_q       <= rx_byte;
              byte_idx_q <= 2'd3;
              if (enabled_q && op_q == OP_BYTE_RD) begin
                re_q   <= 1'b1;
                addr_q <= {hi_q[AHI-1:0], rx_byte};
              end
            end
            default: begin
              byte_idx_q <= '0;
              if (is_enable) begin
                enabled_q <= 1'b1;
              end else if (enabled_q) begin
                if (op_q == OP_BYTE_WR) begin
                  we_q    <= 1'b1;
                  addr_q  <= {hi_q[AHI-1:0], lo_q};
                  wdata_q <= rx_byte;
                end else if (op_q == OP_MULTI && hi_q[7:5] == 3'b100) begin
                  erase_q <= 1'b1;
                  lock_q  <= '0;
                end else if (op_q == OP_MULTI && hi_q[7:2] == 6'b111000 &&
                             lock_q != 2'd3 && hi_q[1:0] == lock_q + 2'd1) begin
                  lock_q <= hi_q[1:0];
                end
              end
            end
          endcase
        end else begin
          if (op_q == OP_PAGE_WR) begin
            we_q    <= 1'b1;
            addr_q  <= {hi_q[AHI-1:0], page_cnt_q};
            wdata_q <= rx_byte;
          end
          if (page_cnt_q == 8'hFF) begin
            state_q <= ST_CMD;
          end else begin
            page_cnt_q <= page_cnt_q + 1'b1;
            if (op_q == OP_PAGE_RD) begin
              re_q   <= 1'b1;
              addr_q <= {hi_q[AHI-1:0], page_cnt_q + 8'd1};
            end
          end
        end
      end
    end
  end

  assign mem_addr_o  = addr_q;
  assign mem_we_o    = we_q;
  assign mem_re_o    = re_q;
  assign mem_wdata_o = wdata_q;
  assign mem_erase_o = erase_q;

  AST_ACCESS_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o || mem_re_o || mem_erase_o) |-> enabled_q); // R4
  AST_ONE_ACCESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mem_we_o, mem_re_o, mem_erase_o})); // R5
  AST_LOCK_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q != $past(lock_q)) |-> (mem_erase_o || lock_q == $past(lock_q) + 2'd1)); // R7
  AST_PAGE_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(state_q == ST_PAGE) && $past(active)) |-> ($past(page_cnt_q) == 8'hFF)); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |=> !(mem_we_o || mem_erase_o)); // R1
endmodule

// File: tb/isp_slave_test.sv
module isp_slave_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic prog_en = 1'b0, sck = 1'b0, mosi = 1'b0;
  logic miso, mem_re, mem_we, mem_erase;
  logic [12:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  isp_slave uut (
    .clk_i(clk), .rst_ni(rst_n), .prog_en_i(prog_en), .sck_i(sck), .mosi_i(mosi),
    .miso_o(miso), .mem_addr_o(mem_addr), .mem_re_o(mem_re), .mem_we_o(mem_we),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_erase_o(mem_erase));

  // behavioural flash: absent key reads as erased
  logic [7:0] flash [int];
  always @(posedge clk) begin
    if (mem_erase) flash.delete();
    else if (mem_we) flash[int'(mem_addr)] = mem_wdata;
    if (mem_re) mem_rdata <= flash.exists(int'(mem_addr)) ? flash[int'(mem_addr)] : 8'hFF;
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      repeat (5) @(negedge clk);
      mosi = tx[i];
      repeat (5) @(negedge clk);
      rx[i] = miso;
      sck = 1'b1;
      repeat (10) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic cmd(input logic [31:0] c, output logic [7:0] r4);
    logic [7:0] d;
    xfer(c[31:24], d);
    xfer(c[23:16], d);
    xfer(c[15:8], d);
    xfer(c[7:0], r4);
  endtask

  // {b1, b2, b3, b4, expected during b4, tag (0 = no check)}
  localparam int N = 26;
  localparam logic [43:0] TBL [N] = '{
    {32'hAC53_0000, 8'h69, 4'd3},  // R3 echo
    {32'h2000_0500, 8'hFF, 4'd4},  // R4 earlier write had no effect
    {32'h4000_125A, 8'h00, 4'd0},
    {32'h2000_1200, 8'h5A, 4'd5},  // R5
    {32'h40FF_FFA3, 8'h00, 4'd0},
    {32'h201F_FF00, 8'hA3, 4'd5},  // R5 top 3 address bits ignored
    {32'h2000_0000, 8'hFF, 4'd5},  // R5 unwritten
    {32'h2400_0000, 8'h00, 4'd8},  // R8 mode 1
    {32'hACE3_0000, 8'h00, 4'd0},
    {32'h2400_0000, 8'h00, 4'd7},  // R7 mode 4 out of order refused
    {32'hACE1_0000, 8'h00, 4'd0},
    {32'h2400_0000, 8'h04, 4'd8},  // R8 mode 2
    {32'hACE2_0000, 8'h00, 4'd0},
    {32'h2400_0000, 8'h0C, 4'd7},  // R7 mode 3
    {32'hACE3_0000, 8'h00, 4'd0},
    {32'h2400_0000, 8'h1C, 4'd8},  // R8 mode 4
    {32'h2800_0000, 8'hA5, 4'd9},  // R9
    {32'h2800_0100, 8'h3C, 4'd9},
    {32'h2800_0200, 8'h0F, 4'd9},
    {32'h2800_0300, 8'hFF, 4'd9},
    {32'hAC80_0000, 8'h00, 4'd0},
    {32'h2000_1200, 8'hFF, 4'd6},  // R6
    {32'h201F_FF00, 8'hFF, 4'd6},
    {32'h2400_0000, 8'h00, 4'd6},  // R6 lock back to mode 1
    {32'hACE2_0000, 8'h00, 4'd0},
    {32'h2400_0000, 8'h00, 4'd7}   // R7 mode 3 skipped from mode 1
  };

  task automatic finish_up;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    check("R1 reset miso", {7'd0, miso}, 8'h00);
    check("R1 reset strobes", {5'd0, mem_we, mem_re, mem_erase}, 8'h00);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    prog_en = 1'b1;
    // R2: bytes clocked before the 64-cycle low window are dropped
    xfer(8'hAC, r);
    xfer(8'h53, r);
    xfer(8'h00, r);
    repeat (100) @(negedge clk);
    // R4: not yet enabled
    cmd(32'h4000_0577, r);
    cmd(32'h2000_0500, r);
    check("R4 read before enable", r, 8'h00);
    cmd(32'hAC53_0000, r);
    check("R2 framing after guard", r, 8'h69);
    for (int i = 0; i < N; i++) begin
      cmd(TBL[i][43:12], r);
      if (TBL[i][3:0] != 4'd0)
        check($sformatf("R%0d row %0d", TBL[i][3:0], i), r, TBL[i][11:4]);
    end
    // R10: page write to 0x0300..0x03FF, then next command decoded
    xfer(8'h50, r);
    xfer(8'h03, r);
    for (int n = 0; n < 256; n++) xfer(8'(n) ^ 8'h5A, r);
    cmd(32'h2003_0000, r);
    check("R10 first byte", r, 8'h5A);
    cmd(32'h2003_FF00, r);
    check("R10 last byte", r, 8'hA5);
    cmd(32'h2004_0000, r);
    check("R10 no overrun", r, 8'hFF);
    // R11: page read
    begin
      int errs = 0;
      xfer(8'h30, r);
      xfer(8'h03, r);
      for (int n = 0; n < 256; n++) begin
        xfer(8'h00, r);
        if (r !== (8'(n) ^ 8'h5A)) begin
          errs++;
          if (errs == 1) $display("FAIL R11 slot %0d: got %h expected %h", n, r, 8'(n) ^ 8'h5A);
        end
      end
      total++;
      if (errs != 0) bad++;
    end
    cmd(32'h2400_0000, r);
    check("R11 next command after page", r, 8'h00);
    // R1: dropping programming mode clears enable
    prog_en = 1'b0;
    repeat (20) @(negedge clk);
    check("R1 idle miso", {7'd0, miso}, 8'h00);
    prog_en = 1'b1;
    repeat (100) @(negedge clk);
    cmd(32'h2003_0000, r);
    check("R1 enable cleared", r, 8'h00);
    cmd(32'hAC53_0000, r);
    cmd(32'h2003_0000, r);
    check("R1 contents kept", r, 8'h5A);
    finish_up();
  end
endmodule